// File: doc/BRIEF.md
# Interrupt Status-Word Swap Sequencer

This block holds the 64-bit current status word of a processor and performs the exchange of that word when an interrupt is taken. Five interrupt classes can raise a request: machine check, program error, supervisor call, external and I/O. When the sequencer is idle and at least one request is enabled by the current word, it accepts the highest-priority one. It then writes the current word to that class's old-word slot in low memory, with the class's 16-bit interruption code and the instruction length code merged in. Next it reads that class's new-word slot and installs the value it reads as the current word.

The same datapath also carries out the load-status-word operation. This operation reads a doubleword from a given address and installs it without storing anything. All memory traffic goes through one doubleword request/acknowledge port. The issue stage of the processor watches `issue_en`: it is low while a swap is in progress and while the current word is in the wait state.

Bit numbering in this text follows the status-word layout, where bit 0 is the most significant bit. Layout bit b is vector index 63-b.

Top module: `psw_swap_seq`

## Requirements
- R1: After reset the current word equals RESET_PSW (default zero), and mem_req, take_pulse and busy are low while issue_en is high.
- R2: An accepted interrupt stores one doubleword to its old slot: 0x30 for machine check, 0x28 for program, 0x20 for supervisor call, 0x18 for external, 0x38 for I/O. The stored word is the current word with layout bits 16-31 (vector [47:32]) replaced by the class code and layout bits 32-33 (vector [31:30]) replaced by ilc_in. All other bits are unchanged.
- R3: After the store, the doubleword at the class's new slot (old slot + 0x40) is read and becomes the current word.
- R4: For a supervisor call the interruption code is {8'h00, svc_num}.
- R5: Machine check is enabled only by layout bit 13 (vector [50]). External is enabled only by layout bit 7 (vector [56]). I/O is enabled only by the system-mask bit numbered io_chan (vector [63-io_chan]), with io_chan 7 never enabled. Program and supervisor call are never masked. A request that is not enabled causes no memory access, no pulse and no change of the current word.
- R6: Among enabled requests the order of acceptance is machine check, then program, then supervisor call, then external, then I/O.
- R7: take_pulse is one-hot and lasts one cycle, in the cycle after acceptance. Bit 0 is machine check, bit 1 program, bit 2 supervisor call, bit 3 external, bit 4 I/O.
- R8: mem_req stays high with stable mem_addr, mem_we and mem_wdata until mem_ack. A swap makes exactly one write (mem_we high) followed by one read.
- R9: A lpsw_req seen while idle with no enabled interrupt reads the doubleword at lpsw_addr and installs it. It makes no write and gives no take_pulse.
- R10: issue_en is low while busy or while layout bit 14 (vector [49]) of the current word is set.
- R11: Requests are ignored while busy: a request held high through a whole swap yields one pulse for that swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_mchk | input | 1 | Machine-check request (level) |
| req_prog | input | 1 | Program-error request (level) |
| req_svc | input | 1 | Supervisor-call request (level) |
| req_ext | input | 1 | External request (level) |
| req_io | input | 1 | I/O request (level) |
| io_chan | input | 3 | Channel of the I/O request, 0 to 6 |
| mchk_code | input | 16 | Interruption code for machine check |
| prog_code | input | 16 | Interruption code for program error |
| ext_code | input | 16 | Interruption code for external |
| io_code | input | 16 | Interruption code for I/O |
| svc_num | input | 8 | Supervisor-call number from the instruction |
| ilc_in | input | 2 | Instruction length code to merge |
| lpsw_req | input | 1 | Load-status-word request |
| lpsw_addr | input | ADDR_W | Doubleword address for the load |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the doubleword |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata | input | 64 | Read data |
| cur_psw | output | 64 | Current status word |
| take_pulse | output | 5 | One-cycle accept pulse per class |
| busy | output | 1 | A swap or load is in progress |
| issue_en | output | 1 | Instruction issue permitted |

## Verification
The assertions assume that the memory raises mem_ack only while mem_req is high, for a single cycle per request, and that the read data is valid in that cycle. The bench memory model acknowledges one cycle after each new request and then drops the acknowledge, so this assumption always holds. The assertions also assume that request levels change only away from the clock edge. The bench changes them only on the falling edge, and it clears a request in the cycle the matching pulse appears, except in the test that deliberately holds a request through a busy swap.

// File: rtl/psw_swap_pkg.sv
package psw_swap_pkg;
  localparam int PSW_W   = 64;
  localparam int NUM_CLS = 5;

  // vector indices of status-word fields (layout bit b is index 63-b)
  localparam int EXT_EN_IDX  = 56;
  localparam int MCHK_EN_IDX = 50;
  localparam int WAIT_IDX    = 49;
  localparam int IC_HI       = 47;
  localparam int IC_LO       = 32;
  localparam int ILC_HI      = 31;
  localparam int ILC_LO      = 30;

  // value equals priority rank and take_pulse bit
  typedef enum logic [2:0] {
    CLS_MCHK = 3'd0,
    CLS_PROG = 3'd1,
    CLS_SVC  = 3'd2,
    CLS_EXT  = 3'd3,
    CLS_IO   = 3'd4
  } irq_cls_e;

  function automatic logic [7:0] old_slot(irq_cls_e c);
    case (c)
      CLS_EXT:  return 8'h18;
      CLS_SVC:  return 8'h20;
      CLS_PROG: return 8'h28;
      CLS_MCHK: return 8'h30;
      default:  return 8'h38;
    endcase
  endfunction

  function automatic logic [7:0] new_slot(irq_cls_e c);
    return old_slot(c) + 8'h40;
  endfunction
endpackage

// File: rtl/psw_req_arbiter.sv
module psw_req_arbiter #(
  parameter int NUM_CLS = 5
) (
  input  logic [NUM_CLS-1:0] req_vec,
  input  logic [NUM_CLS-1:0] en_vec,
  output logic [NUM_CLS-1:0] grant,
  output logic               any_grant
);
  logic [NUM_CLS-1:0] live;
  logic [NUM_CLS:0]   blocked;

  assign live       = req_vec & en_vec;
  assign blocked[0] = 1'b0;

  // lowest index has highest priority
  for (genvar i = 0; i < NUM_CLS; i++) begin : g_prio
    assign grant[i]     = live[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | live[i];
  end

  assign any_grant = blocked[NUM_CLS];
endmodule

// File: rtl/psw_word_merge.sv
module psw_word_merge
  import psw_swap_pkg::*;
#(
  parameter int NUM_CLS = 5
) (
  input  logic [PSW_W-1:0]   cur_word,
  input  logic [NUM_CLS-1:0] grant,
  input  logic [15:0]        mchk_code,
  input  logic [15:0]        prog_code,
  input  logic [15:0]        ext_code,
  input  logic [15:0]        io_code,
  input  logic [7:0]         svc_num,
  input  logic [1:0]         ilc_in,
  output logic [PSW_W-1:0]   merged
);
  logic [15:0] code;

  always_comb begin
    code = io_code;
    if (grant[CLS_MCHK])      code = mchk_code;
    else if (grant[CLS_PROG]) code = prog_code;
    else if (grant[CLS_SVC])  code = {8'h00, svc_num};
    else if (grant[CLS_EXT])  code = ext_code;
  end

  always_comb begin
    merged                = cur_word;
    merged[IC_HI:IC_LO]   = code;
    merged[ILC_HI:ILC_LO] = ilc_in;
  end
endmodule

// File: rtl/psw_swap_fsm.sv
module psw_swap_fsm
  import psw_swap_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int NUM_CLS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CLS-1:0] grant,
  input  logic               any_grant,
  input  logic [PSW_W-1:0]   merged,
  input  logic               lpsw_req,
  input  logic [ADDR_W-1:0]  lpsw_addr,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [PSW_W-1:0]   mem_wdata,
  input  logic               mem_ack,
  input  logic [PSW_W-1:0]   mem_rdata,
  output logic [NUM_CLS-1:0] take_pulse,
  output logic               install_en,
  output logic [PSW_W-1:0]   install_word,
  output logic               busy
);
  typedef enum logic [1:0] {S_IDLE, S_STORE, S_FETCH, S_INSTALL} st_e;

  st_e                state_q, state_d;
  logic [PSW_W-1:0]   store_q, store_d, fetch_q, fetch_d;
  logic [ADDR_W-1:0]  st_addr_q, st_addr_d, fe_addr_q, fe_addr_d;
  logic [NUM_CLS-1:0] take_q, take_d;
  irq_cls_e           gcls;

  always_comb begin
    gcls = CLS_IO;
    for (int i = NUM_CLS - 1; i >= 0; i--)
      if (grant[i]) gcls = irq_cls_e'(3'(i));
  end

  always_comb begin
    state_d   = state_q;
    store_d   = store_q;
    fetch_d   = fetch_q;
    st_addr_d = st_addr_q;
    fe_addr_d = fe_addr_q;
    take_d    = '0;
    case (state_q)
      S_IDLE: begin
        if (any_grant) begin
          state_d   = S_STORE;
          store_d   = merged;
          st_addr_d = ADDR_W'(old_slot(gcls));
          fe_addr_d = ADDR_W'(new_slot(gcls));
          take_d    = grant;
        end else if (lpsw_req) begin
          state_d   = S_FETCH;
          fe_addr_d = lpsw_addr;
        end
      end
      S_STORE: if (mem_ack) state_d = S_FETCH;
      S_FETCH: if (mem_ack) begin
        state_d = S_INSTALL;
        fetch_d = mem_rdata;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      store_q   <= '0;
      fetch_q   <= '0;
      st_addr_q <= '0;
      fe_addr_q <= '0;
      take_q    <= '0;
    end else begin
      state_q   <= state_d;
      store_q   <= store_d;
      fetch_q   <= fetch_d;
      st_addr_q <= st_addr_d;
      fe_addr_q <= fe_addr_d;
      take_q    <= take_d;
    end
  end

  assign mem_req      = (state_q == S_STORE) || (state_q == S_FETCH);
  assign mem_we       = (state_q == S_STORE);
  assign mem_addr     = (state_q == S_STORE) ? st_addr_q : fe_addr_q;
  assign mem_wdata    = store_q;
  assign take_pulse   = take_q;
  assign install_en   = (state_q == S_INSTALL);
  assign install_word = fetch_q;
  assign busy         = (state_q != S_IDLE);

  // R7
  take_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_pulse));

  // R11
  take_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|take_pulse) |-> ($past(state_q) == S_IDLE));

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  // R8
  store_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));
endmodule

// File: rtl/psw_swap_seq.sv
module psw_swap_seq
  import psw_swap_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter logic [63:0] RESET_PSW = 64'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_mchk,
  input  logic              req_prog,
  input  logic              req_svc,
  input  logic              req_ext,
  input  logic              req_io,
  input  logic [2:0]        io_chan,
  input  logic [15:0]       mchk_code,
  input  logic [15:0]       prog_code,
  input  logic [15:0]       ext_code,
  input  logic [15:0]       io_code,
  input  logic [7:0]        svc_num,
  input  logic [1:0]        ilc_in,
  input  logic              lpsw_req,
  input  logic [ADDR_W-1:0] lpsw_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata,
  output logic [63:0]       cur_psw,
  output logic [4:0]        take_pulse,
  output logic              busy,
  output logic              issue_en
);
  logic [PSW_W-1:0]   psw_q, psw_d, merged, install_word;
  logic [NUM_CLS-1:0] req_vec, en_vec, grant;
  logic               any_grant, install_en, io_en;

  assign io_en = (io_chan != 3'd7) && psw_q[PSW_W - 1 - int'(io_chan)];

  always_comb begin
    req_vec           = '0;
    en_vec            = '0;
    req_vec[CLS_MCHK] = req_mchk;
    req_vec[CLS_PROG] = req_prog;
    req_vec[CLS_SVC]  = req_svc;
    req_vec[CLS_EXT]  = req_ext;
    req_vec[CLS_IO]   = req_io;
    en_vec[CLS_MCHK]  = psw_q[MCHK_EN_IDX];
    en_vec[CLS_PROG]  = 1'b1;
    en_vec[CLS_SVC]   = 1'b1;
    en_vec[CLS_EXT]   = psw_q[EXT_EN_IDX];
    en_vec[CLS_IO]    = io_en;
  end

  psw_req_arbiter #(.NUM_CLS(NUM_CLS)) arb_i (
    .req_vec(req_vec), .en_vec(en_vec), .grant(grant), .any_grant(any_grant)
  );

  psw_word_merge #(.NUM_CLS(NUM_CLS)) merge_i (
    .cur_word(psw_q), .grant(grant), .mchk_code(mchk_code),
    .prog_code(prog_code), .ext_code(ext_code), .io_code(io_code),
    .svc_num(svc_num), .ilc_in(ilc_in), .merged(merged)
  );

  psw_swap_fsm #(.ADDR_W(ADDR_W), .NUM_CLS(NUM_CLS)) fsm_i (
    .clk(clk), .rst_n(rst_n), .grant(grant), .any_grant(any_grant),
    .merged(merged), .lpsw_req(lpsw_req), .lpsw_addr(lpsw_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .take_pulse(take_pulse), .install_en(install_en),
    .install_word(install_word), .busy(busy)
  );

  always_comb begin
    psw_d = psw_q;
    if (install_en) psw_d = install_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psw_q <= RESET_PSW;
    else        psw_q <= psw_d;
  end

  assign cur_psw  = psw_q;
  assign issue_en = !busy && !psw_q[WAIT_IDX];

  // R5
  ext_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse[CLS_EXT] |-> $past(psw_q[EXT_EN_IDX]));

  // R5
  mchk_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse[CLS_MCHK] |-> $past(psw_q[MCHK_EN_IDX]));

  // R6
  mchk_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_mchk && psw_q[MCHK_EN_IDX]) |=> take_pulse[CLS_MCHK]);

  // R10
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psw_q[WAIT_IDX] || busy) |-> !issue_en);
endmodule

// File: tb/psw_swap_seq_tb.sv
module psw_swap_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int NVEC = 12;
  // {mask8, mchk_en, reqs[4:0] (bit=class), io_chan, class (7 = none)}
  localparam logic [19:0] VEC [NVEC] = '{
    {8'h00, 1'b0, 5'b00010, 3'd0, 3'd1},
    {8'h00, 1'b0, 5'b00100, 3'd0, 3'd2},
    {8'h01, 1'b0, 5'b01000, 3'd0, 3'd3},
    {8'h10, 1'b0, 5'b10000, 3'd3, 3'd4},
    {8'h00, 1'b1, 5'b00001, 3'd0, 3'd0},
    {8'hFF, 1'b1, 5'b11111, 3'd2, 3'd0},
    {8'hFF, 1'b1, 5'b11110, 3'd2, 3'd1},
    {8'hFF, 1'b1, 5'b11100, 3'd2, 3'd2},
    {8'hFF, 1'b1, 5'b11000, 3'd2, 3'd3},
    {8'h40, 1'b0, 5'b10001, 3'd1, 3'd4},
    {8'h04, 1'b0, 5'b11000, 3'd5, 3'd4},
    {8'hFE, 1'b1, 5'b11000, 3'd7, 3'd7}
  };
  localparam logic [15:0] C_MCHK = 16'h0A11, C_PROG = 16'h0006;
  localparam logic [15:0] C_EXT = 16'h0040, C_IO = 16'h0123;
  localparam logic [7:0]  C_SVC = 8'h2C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_mchk = 0, req_prog = 0, req_svc = 0, req_ext = 0, req_io = 0;
  logic [2:0] io_chan = '0;
  logic lpsw_req = 0;
  logic [ADDR_W-1:0] lpsw_addr = 24'h000200;
  logic mem_req, mem_we, mem_ack, busy, issue_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata, cur_psw;
  logic [4:0] take_pulse;
  logic [63:0] mem [128];
  int wr_cnt;
  logic [ADDR_W-1:0] last_wa;
  logic [63:0] last_wd;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psw_swap_seq #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_mchk(req_mchk), .req_prog(req_prog),
    .req_svc(req_svc), .req_ext(req_ext), .req_io(req_io), .io_chan(io_chan),
    .mchk_code(C_MCHK), .prog_code(C_PROG), .ext_code(C_EXT), .io_code(C_IO),
    .svc_num(C_SVC), .ilc_in(2'b10), .lpsw_req(lpsw_req), .lpsw_addr(lpsw_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cur_psw(cur_psw), .take_pulse(take_pulse), .busy(busy), .issue_en(issue_en)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
      wr_cnt <= 0;
      last_wa <= '0;
      last_wd <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) mem_rdata <= mem[mem_addr[9:3]];
      if (mem_req && mem_we && mem_ack) begin
        mem[mem_addr[9:3]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
        last_wa <= mem_addr;
        last_wd <= mem_wdata;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] old_addr(input int c);
    case (c)
      0: return 8'h30;
      1: return 8'h28;
      2: return 8'h20;
      3: return 8'h18;
      default: return 8'h38;
    endcase
  endfunction

  function automatic logic [15:0] code_of(input int c);
    case (c)
      0: return C_MCHK;
      1: return C_PROG;
      2: return {8'h00, C_SVC};
      3: return C_EXT;
      default: return C_IO;
    endcase
  endfunction

  function automatic logic [63:0] new_word(input int c);
    return {40'h0, 24'h001000 + 24'(c * 256)};
  endfunction

  function automatic logic [63:0] mk_start(input logic [7:0] m, input logic mc,
                                           input logic wt);
    return {m, 4'h3, 1'b0, mc, wt, 1'b1, 16'hFFFF, 2'b01, 2'b10, 4'h5, 24'h00ABC0};
  endfunction

  task automatic drop_reqs();
    req_mchk = 0; req_prog = 0; req_svc = 0; req_ext = 0; req_io = 0;
  endtask

  task automatic do_lpsw(input logic [63:0] w, input string tag);
    int w0;
    mem[64] = w;
    w0 = wr_cnt;
    @(negedge clk);
    lpsw_req = 1;
    @(negedge clk);
    lpsw_req = 0;
    for (int i = 0; i < 20 && busy; i++) @(negedge clk);
    // R9
    chk(cur_psw == w && wr_cnt == w0, {"R9 load ", tag}, cur_psw, w);
  endtask

  // waits for one swap; returns first pulse and number of pulse cycles
  task automatic run_swap(input bit hold, output logic [4:0] pv, output int np);
    pv = '0;
    np = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (take_pulse != 0) begin
        np++;
        if (np == 1) pv = take_pulse;
        if (!hold) drop_reqs();
      end
      if (np > 0 && !busy) break;
    end
    drop_reqs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [4:0] pv;
    int np, w0;
    logic [63:0] st, exp_w;
    for (int i = 0; i < 128; i++) mem[i] = 64'h0;
    for (int c = 0; c < 5; c++) mem[(32'(old_addr(c)) + 32'h40) >> 3] = new_word(c);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(cur_psw == 64'h0, "R1 reset word", cur_psw, 64'h0);
    chk({mem_req, take_pulse, busy, issue_en} == 8'b0000_0001, "R1 reset outputs",
        {56'h0, mem_req, take_pulse, busy, issue_en}, 64'h1);

    foreach (VEC[v]) begin
      st = mk_start(VEC[v][19:12], VEC[v][11], 1'b0);
      do_lpsw(st, $sformatf("vec %0d", v));
      w0 = wr_cnt;
      io_chan = VEC[v][5:3];
      req_mchk = VEC[v][6]; req_prog = VEC[v][7]; req_svc = VEC[v][8];
      req_ext = VEC[v][9]; req_io = VEC[v][10];
      if (VEC[v][2:0] == 3'd7) begin
        np = 0;
        for (int i = 0; i < 8; i++) begin
          @(negedge clk);
          if (take_pulse != 0) np++;
        end
        drop_reqs();
        // R5
        chk(np == 0 && !busy && cur_psw == st && wr_cnt == w0,
            "R5 masked requests ignored", cur_psw, st);
      end else begin
        int c;
        c = int'(VEC[v][2:0]);
        run_swap(1'b0, pv, np);
        // R6 R7
        chk(pv == 5'(1 << c) && np == 1, $sformatf("R6/R7 pulse vec %0d", v),
            {59'h0, pv}, 64'(1 << c));
        exp_w = st;
        exp_w[47:32] = code_of(c);
        exp_w[31:30] = 2'b10;
        // R2
        chk(last_wa == 24'(old_addr(c)), $sformatf("R2 old slot vec %0d", v),
            64'(last_wa), 64'(old_addr(c)));
        chk(last_wd == exp_w, $sformatf("R2 saved word vec %0d", v), last_wd, exp_w);
        if (c == 2)
          chk(last_wd[47:32] == 16'h002C, "R4 svc code", 64'(last_wd[47:32]), 64'h2C);
        // R8
        chk(wr_cnt - w0 == 1, "R8 single write", 64'(wr_cnt - w0), 64'h1);
        // R3
        chk(cur_psw == new_word(c), $sformatf("R3 new word vec %0d", v),
            cur_psw, new_word(c));
      end
    end

    // R11: program request held through the whole swap
    do_lpsw(mk_start(8'h00, 1'b0, 1'b0), "r11 setup");
    req_prog = 1;
    run_swap(1'b1, pv, np);
    chk(np == 1 && pv == 5'b00010, "R11 busy ignores requests", 64'(np), 64'h1);

    // R10: wait state holds issue until an enabled interrupt is taken
    do_lpsw(mk_start(8'h01, 1'b0, 1'b1), "r10 setup");
    chk(issue_en == 1'b0, "R10 wait holds issue", 64'(issue_en), 64'h0);
    req_ext = 1;
    @(negedge clk);
    req_ext = 0;
    chk(busy && issue_en == 1'b0, "R10 no issue while busy", 64'(issue_en), 64'h0);
    for (int i = 0; i < 20 && busy; i++) @(negedge clk);
    chk(issue_en == 1'b1 && cur_psw == new_word(3), "R10 issue resumes",
        cur_psw, new_word(3));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule